// File: doc/BRIEF.md
# BCD Calendar Counter Chain

This block keeps time of day and calendar date as packed BCD bytes, from hundredths of a second up to a two-digit year, plus a day-of-week count. A 100 Hz enable pulse from a prescaler outside the block advances the chain while the run control is high. Each counter byte can be loaded directly from a host byte-write port. A mode input picks 24-hour counting or 12-hour counting with a morning/afternoon flag. February's length comes from a two-bit count of years since the last leap year. This count advances at each year rollover and can also be loaded by the host.

A set of shadow registers holds seconds, minutes, hours, day of month and month. While the save-enable flag is set, the shadow registers copy the live counters. Once the flag is cleared, they hold their last value, so software can read a consistent time. The flag is also cleared by a standby-entry input, which captures the time at that moment.

For each carry in the chain the block also emits a registered single-cycle strobe. These strobes feed a periodic-interrupt block elsewhere in the chip.

Top module: `cal_chain`

## Requirements
- R1: After synchronous reset, hundredths, seconds, minutes, hours and year read 00. Day of month, month and day of week read 01. The leap count, save-enable flag, shadow registers and all strobes read 0.
- R2: When run=1 and tick=1 at a clock edge, the hundredths byte advances by one in BCD. It wraps from 99 to 00, and that wrap advances the seconds.
- R3: Seconds and minutes count 00 to 59 in BCD. Each wraps to 00 and carries into the next unit.
- R4: With mode_12h=0, hours count 00 to 23. The wrap from 23 to 00 advances the day of month and the day of week.
- R5: With mode_12h=1, the hours byte holds the hour 01 to 12 in bits 4:0 and the afternoon flag in bit 7 (0 = AM, 1 = PM). The hour goes from 12 to 01. The flag toggles whenever the hour becomes 12. The step from 11 PM to 12 AM advances the day.
- R6: The day of month wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in all other months except February. February ends at 29 when the leap count is 0 and at 28 otherwise. The day wrap advances the month (wraps 12 to 01). The month wrap advances the year (wraps 99 to 00).
- R7: The two-bit leap count advances by one, wrapping 3 to 0, when December 31 rolls over.
- R8: The day of week counts 1 to 7 and wraps to 1 on each day advance.
- R9: While run=0, ticks are ignored and no counter changes.
- R10: With wr_en=1, wr_data is loaded into the unit chosen by wr_sel. The codes are 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day of month, 5 month, 6 year, 7 day of week, 8 leap count. A write takes priority over an increment of that unit in the same cycle. Only the used bits are stored; all others read 0. The stored masks are seconds and minutes 7F, hours 3F in 24-hour mode or 9F in 12-hour mode, day 3F, month 1F, day of week 07, and leap 03.
- R11: roll_o is registered with the counters and high for one cycle per carry. Bit 0 is the hundredths digit carry. Bit 1 is the hundredths wrap. Bit 2 is the seconds units carry. Bit 3 is the seconds wrap. Bit 4 is the minutes wrap. Bit 5 is the hours (day) wrap. Bit 6 is the day-of-month wrap. Bit 7 is the month wrap.
- R12: ts_wr loads the save-enable flag from ts_data. While the flag is 1, each shadow register takes the value its live counter had one cycle earlier. While it is 0, the shadow registers hold.
- R13: standby=1 clears the save-enable flag at the next edge, overriding ts_wr. The shadow registers keep the live time from the cycle in which standby was seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 100 Hz advance enable, one cycle wide |
| run | input | 1 | 1 = count, 0 = chain stopped |
| mode_12h | input | 1 | 1 = 12-hour mode, 0 = 24-hour mode |
| wr_en | input | 1 | Host counter write strobe |
| wr_sel | input | 4 | Unit select for a write |
| wr_data | input | 8 | Write data, BCD |
| ts_wr | input | 1 | Write strobe for save-enable flag |
| ts_data | input | 1 | New save-enable value |
| standby | input | 1 | Standby entry; clears save enable |
| hund_o | output | 8 | Hundredths of a second |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours (bit 7 = PM in 12-hour mode) |
| dom_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Year |
| dow_o | output | 8 | Day of week |
| leap_o | output | 2 | Years since last leap year |
| save_en_o | output | 1 | Save-enable flag |
| sv_sec_o | output | 8 | Shadow seconds |
| sv_min_o | output | 8 | Shadow minutes |
| sv_hour_o | output | 8 | Shadow hours |
| sv_dom_o | output | 8 | Shadow day of month |
| sv_mon_o | output | 8 | Shadow month |
| roll_o | output | 8 | Carry strobes |

## Verification
Each vector preloads the whole chain and applies a single tick, so one step can exercise carries of any depth. A plain hundredths step shows that the count advances without a strobe. A digit carry alone, and a carry into the seconds units, show that each stage stops where it should. A full year-end wrap and the February cases with leap counts 0 and 1 separate the month-length rules. The 30-day and 31-day months are compared against each other. Three 12-hour steps (11 AM, 12 PM and 11 PM) separate the hour wrap from the flag toggle and the day carry.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int BYTE_W  = 8;
  localparam int SEL_W   = 4;
  localparam int LEAP_W  = 2;
  localparam int DOW_W   = 3;
  localparam int N_ROLL  = 8;
  localparam int N_SAVE  = 5;

  localparam logic [SEL_W-1:0] SEL_HUND = 4'd0;
  localparam logic [SEL_W-1:0] SEL_SEC  = 4'd1;
  localparam logic [SEL_W-1:0] SEL_MIN  = 4'd2;
  localparam logic [SEL_W-1:0] SEL_HOUR = 4'd3;
  localparam logic [SEL_W-1:0] SEL_DOM  = 4'd4;
  localparam logic [SEL_W-1:0] SEL_MON  = 4'd5;
  localparam logic [SEL_W-1:0] SEL_YEAR = 4'd6;
  localparam logic [SEL_W-1:0] SEL_DOW  = 4'd7;
  localparam logic [SEL_W-1:0] SEL_LEAP = 4'd8;

  // one BCD step on a two-digit byte
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // step with a wrap from top back to bottom
  function automatic logic [7:0] bcd_wrap(input logic [7:0] v,
                                          input logic [7:0] top,
                                          input logic [7:0] bottom);
    if (v == top) return bottom;
    else          return bcd_inc(v);
  endfunction

  // last day of the month in BCD
  function automatic logic [7:0] month_len(input logic [7:0] m,
                                           input logic [LEAP_W-1:0] lp);
    case (m)
      8'h02:                      return (lp == '0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_time_cnt.sv
module cal_time_cnt
  import cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             mode_12h,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [7:0]       wr_data,
  output logic [7:0]       hund_q,
  output logic [7:0]       sec_q,
  output logic [7:0]       min_q,
  output logic [7:0]       hour_q,
  output logic [5:0]       carry_o
);
  logic c_hd, c_hw, c_sd, c_sw, c_mw, c_hr;
  logic [4:0] h12;
  logic [7:0] hour_nxt;

  assign c_hd = adv  && (hund_q[3:0] == 4'd9);
  assign c_hw = adv  && (hund_q == 8'h99);
  assign c_sd = c_hw && (sec_q[3:0] == 4'd9);
  assign c_sw = c_hw && (sec_q == 8'h59);
  assign c_mw = c_sw && (min_q == 8'h59);
  assign c_hr = c_mw && (mode_12h ? (hour_q == 8'h91) : (hour_q == 8'h23));
  assign carry_o = {c_hr, c_mw, c_sw, c_sd, c_hw, c_hd};

  always_comb begin
    if (hour_q[4:0] == 5'h12)       h12 = 5'h01;
    else if (hour_q[3:0] == 4'd9)   h12 = 5'h10;
    else                            h12 = {hour_q[4], hour_q[3:0] + 4'd1};
    if (mode_12h) hour_nxt = {hour_q[7] ^ (h12 == 5'h12), 2'b00, h12};
    else          hour_nxt = bcd_wrap(hour_q, 8'h23, 8'h00);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hund_q <= 8'h00;
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else begin
      if (wr_en && wr_sel == SEL_HUND) hund_q <= wr_data;
      else if (adv)                    hund_q <= bcd_wrap(hund_q, 8'h99, 8'h00);

      if (wr_en && wr_sel == SEL_SEC)  sec_q <= wr_data & 8'h7F;
      else if (c_hw)                   sec_q <= bcd_wrap(sec_q, 8'h59, 8'h00);

      if (wr_en && wr_sel == SEL_MIN)  min_q <= wr_data & 8'h7F;
      else if (c_sw)                   min_q <= bcd_wrap(min_q, 8'h59, 8'h00);

      if (wr_en && wr_sel == SEL_HOUR) hour_q <= wr_data & (mode_12h ? 8'h9F : 8'h3F);
      else if (c_mw)                   hour_q <= hour_nxt;
    end
  end
endmodule

// File: rtl/cal_date_cnt.sv
module cal_date_cnt
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              day_inc,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [7:0]        wr_data,
  output logic [7:0]        dom_q,
  output logic [7:0]        mon_q,
  output logic [7:0]        year_q,
  output logic [DOW_W-1:0]  dow_q,
  output logic [LEAP_W-1:0] leap_q,
  output logic [1:0]        carry_o
);
  logic c_dw, c_mo;

  assign c_dw    = day_inc && (dom_q == month_len(mon_q, leap_q));
  assign c_mo    = c_dw && (mon_q == 8'h12);
  assign carry_o = {c_mo, c_dw};

  always_ff @(posedge clk) begin
    if (rst) begin
      dom_q  <= 8'h01;
      mon_q  <= 8'h01;
      year_q <= 8'h00;
      dow_q  <= DOW_W'(1);
      leap_q <= '0;
    end else begin
      if (wr_en && wr_sel == SEL_DOM)  dom_q <= wr_data & 8'h3F;
      else if (day_inc)                dom_q <= c_dw ? 8'h01 : bcd_inc(dom_q);

      if (wr_en && wr_sel == SEL_MON)  mon_q <= wr_data & 8'h1F;
      else if (c_dw)                   mon_q <= bcd_wrap(mon_q, 8'h12, 8'h01);

      if (wr_en && wr_sel == SEL_YEAR) year_q <= wr_data;
      else if (c_mo)                   year_q <= bcd_wrap(year_q, 8'h99, 8'h00);

      if (wr_en && wr_sel == SEL_DOW)  dow_q <= wr_data[DOW_W-1:0];
      else if (day_inc)                dow_q <= (dow_q == DOW_W'(7)) ? DOW_W'(1) : dow_q + DOW_W'(1);

      if (wr_en && wr_sel == SEL_LEAP) leap_q <= wr_data[LEAP_W-1:0];
      else if (c_mo)                   leap_q <= leap_q + LEAP_W'(1);
    end
  end
endmodule

// File: rtl/cal_shadow.sv
module cal_shadow
  import cal_pkg::*;
#(
  parameter int N = N_SAVE,
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ts_wr,
  input  logic         ts_data,
  input  logic         standby,
  input  logic [N*W-1:0] live,
  output logic         save_en_q,
  output logic [N*W-1:0] shadow_q
);
  always_ff @(posedge clk) begin
    if (rst)          save_en_q <= 1'b0;
    else if (standby) save_en_q <= 1'b0;
    else if (ts_wr)   save_en_q <= ts_data;
  end

  for (genvar g = 0; g < N; g++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst)            shadow_q[g*W +: W] <= '0;
      else if (save_en_q) shadow_q[g*W +: W] <= live[g*W +: W];
    end
  end
endmodule

// File: rtl/cal_chain.sv
module cal_chain
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run,
  input  logic              mode_12h,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [7:0]        wr_data,
  input  logic              ts_wr,
  input  logic              ts_data,
  input  logic              standby,
  output logic [7:0]        hund_o,
  output logic [7:0]        sec_o,
  output logic [7:0]        min_o,
  output logic [7:0]        hour_o,
  output logic [7:0]        dom_o,
  output logic [7:0]        mon_o,
  output logic [7:0]        year_o,
  output logic [7:0]        dow_o,
  output logic [LEAP_W-1:0] leap_o,
  output logic              save_en_o,
  output logic [7:0]        sv_sec_o,
  output logic [7:0]        sv_min_o,
  output logic [7:0]        sv_hour_o,
  output logic [7:0]        sv_dom_o,
  output logic [7:0]        sv_mon_o,
  output logic [N_ROLL-1:0] roll_o
);
  logic              adv;
  logic [5:0]        t_carry;
  logic [1:0]        d_carry;
  logic [DOW_W-1:0]  dow_q;
  logic [N_ROLL-1:0] roll_q;
  logic [N_SAVE*BYTE_W-1:0] live, shadow;

  assign adv = tick && run;

  cal_time_cnt u_time (
    .clk(clk), .rst(rst), .adv(adv), .mode_12h(mode_12h),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hund_q(hund_o), .sec_q(sec_o), .min_q(min_o), .hour_q(hour_o),
    .carry_o(t_carry)
  );

  cal_date_cnt u_date (
    .clk(clk), .rst(rst), .day_inc(t_carry[5]),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .dom_q(dom_o), .mon_q(mon_o), .year_q(year_o), .dow_q(dow_q),
    .leap_q(leap_o), .carry_o(d_carry)
  );

  assign live = {mon_o, dom_o, hour_o, min_o, sec_o};

  cal_shadow #(.N(N_SAVE), .W(BYTE_W)) u_save (
    .clk(clk), .rst(rst), .ts_wr(ts_wr), .ts_data(ts_data),
    .standby(standby), .live(live),
    .save_en_q(save_en_o), .shadow_q(shadow)
  );

  always_ff @(posedge clk) begin
    if (rst) roll_q <= '0;
    else     roll_q <= {d_carry, t_carry};
  end

  assign roll_o    = roll_q;
  assign dow_o     = {{(8-DOW_W){1'b0}}, dow_q};
  assign sv_sec_o  = shadow[0*BYTE_W +: BYTE_W];
  assign sv_min_o  = shadow[1*BYTE_W +: BYTE_W];
  assign sv_hour_o = shadow[2*BYTE_W +: BYTE_W];
  assign sv_dom_o  = shadow[3*BYTE_W +: BYTE_W];
  assign sv_mon_o  = shadow[4*BYTE_W +: BYTE_W];
endmodule

// File: rtl/cal_chain_chk.sv
module cal_chain_chk (
  input logic       clk,
  input logic       rst,
  input logic       run,
  input logic       wr_en,
  input logic       mode_12h,
  input logic       standby,
  input logic       save_en,
  input logic [7:0] hund,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hour,
  input logic [7:0] dom,
  input logic [7:0] sv_sec,
  input logic [7:0] sv_mon,
  input logic [7:0] roll
);
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_en) |=> ($stable(hund) && $stable(sec) && $stable(min) && $stable(hour) && $stable(dom))); // R9

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (roll[3] && !$past(wr_en)) |-> (sec == 8'h00)); // R3

  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (rst)
    (roll[6] && !$past(wr_en)) |-> (dom == 8'h01)); // R6

  AST_MIDNIGHT_12H: assert property (@(posedge clk) disable iff (rst)
    (roll[5] && $past(mode_12h) && !$past(wr_en)) |-> (hour == 8'h12)); // R5

  AST_STANDBY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    standby |=> !save_en); // R13

  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !save_en |=> ($stable(sv_sec) && $stable(sv_mon))); // R12
endmodule

bind cal_chain cal_chain_chk u_chk (
  .clk(clk), .rst(rst), .run(run), .wr_en(wr_en), .mode_12h(mode_12h),
  .standby(standby), .save_en(save_en_o), .hund(hund_o), .sec(sec_o),
  .min(min_o), .hour(hour_o), .dom(dom_o), .sv_sec(sv_sec_o),
  .sv_mon(sv_mon_o), .roll(roll_o)
);

// File: tb/sim_cal_chain.sv
`timescale 1ns/1ps
module sim_cal_chain;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, run = 1'b0, mode_12h = 1'b0;
  logic       wr_en = 1'b0, ts_wr = 1'b0, ts_data = 1'b0, standby = 1'b0;
  logic [3:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] hund_o, sec_o, min_o, hour_o, dom_o, mon_o, year_o, dow_o;
  logic [1:0] leap_o;
  logic       save_en_o;
  logic [7:0] sv_sec_o, sv_min_o, sv_hour_o, sv_dom_o, sv_mon_o, roll_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cal_chain u0 (.*);

  typedef struct packed {
    logic [7:0] mode, leap, hund, sec, min, hour, dom, mon, year, dow;
    logic [7:0] e_leap, e_hund, e_sec, e_min, e_hour, e_dom, e_mon, e_year, e_dow, e_roll;
  } vec_t;

  // preset state, then expected state and strobes after one tick
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    // R2 plain step
    '{8'h0,8'h0,8'h05,8'h00,8'h00,8'h00,8'h01,8'h01,8'h00,8'h01, 8'h0,8'h06,8'h00,8'h00,8'h00,8'h01,8'h01,8'h00,8'h01,8'h00},
    // R2 R11 digit carry
    '{8'h0,8'h0,8'h09,8'h00,8'h00,8'h00,8'h01,8'h01,8'h00,8'h01, 8'h0,8'h10,8'h00,8'h00,8'h00,8'h01,8'h01,8'h00,8'h01,8'h01},
    // R3 seconds units carry
    '{8'h0,8'h0,8'h99,8'h09,8'h00,8'h00,8'h01,8'h01,8'h00,8'h01, 8'h0,8'h00,8'h10,8'h00,8'h00,8'h01,8'h01,8'h00,8'h01,8'h07},
    // R3 seconds wrap into minutes
    '{8'h0,8'h0,8'h99,8'h59,8'h12,8'h00,8'h01,8'h01,8'h00,8'h01, 8'h0,8'h00,8'h00,8'h13,8'h00,8'h01,8'h01,8'h00,8'h01,8'h0F},
    // R4 R6 R7 R8 full year wrap
    '{8'h0,8'h3,8'h99,8'h59,8'h59,8'h23,8'h31,8'h12,8'h99,8'h07, 8'h0,8'h00,8'h00,8'h00,8'h00,8'h01,8'h01,8'h00,8'h01,8'hFF},
    // R6 Feb 28, non-leap
    '{8'h0,8'h1,8'h99,8'h59,8'h59,8'h23,8'h28,8'h02,8'h21,8'h02, 8'h1,8'h00,8'h00,8'h00,8'h00,8'h01,8'h03,8'h21,8'h03,8'h7F},
    // R6 Feb 28, leap
    '{8'h0,8'h0,8'h99,8'h59,8'h59,8'h23,8'h28,8'h02,8'h24,8'h02, 8'h0,8'h00,8'h00,8'h00,8'h00,8'h29,8'h02,8'h24,8'h03,8'h3F},
    // R6 Feb 29, leap
    '{8'h0,8'h0,8'h99,8'h59,8'h59,8'h23,8'h29,8'h02,8'h24,8'h03, 8'h0,8'h00,8'h00,8'h00,8'h00,8'h01,8'h03,8'h24,8'h04,8'h7F},
    // R6 30-day month
    '{8'h0,8'h2,8'h99,8'h59,8'h59,8'h23,8'h30,8'h04,8'h22,8'h05, 8'h2,8'h00,8'h00,8'h00,8'h00,8'h01,8'h05,8'h22,8'h06,8'h7F},
    // R6 31-day month
    '{8'h0,8'h2,8'h99,8'h59,8'h59,8'h23,8'h30,8'h01,8'h22,8'h06, 8'h2,8'h00,8'h00,8'h00,8'h00,8'h31,8'h01,8'h22,8'h07,8'h3F},
    // R5 11 AM to 12 PM
    '{8'h1,8'h0,8'h99,8'h59,8'h59,8'h11,8'h10,8'h06,8'h30,8'h04, 8'h0,8'h00,8'h00,8'h00,8'h92,8'h10,8'h06,8'h30,8'h04,8'h1F},
    // R5 12 PM to 1 PM
    '{8'h1,8'h0,8'h99,8'h59,8'h59,8'h92,8'h10,8'h06,8'h30,8'h04, 8'h0,8'h00,8'h00,8'h00,8'h81,8'h10,8'h06,8'h30,8'h04,8'h1F},
    // R5 11 PM to 12 AM, day carry
    '{8'h1,8'h0,8'h99,8'h59,8'h59,8'h91,8'h10,8'h06,8'h30,8'h03, 8'h0,8'h00,8'h00,8'h00,8'h12,8'h11,8'h06,8'h30,8'h04,8'h3F},
    // R4 24-hour digit carry
    '{8'h0,8'h0,8'h99,8'h59,8'h59,8'h09,8'h10,8'h06,8'h30,8'h04, 8'h0,8'h00,8'h00,8'h00,8'h10,8'h10,8'h06,8'h30,8'h04,8'h1F},
    // R7 leap count 1 -> 2 at year end
    '{8'h0,8'h1,8'h99,8'h59,8'h59,8'h23,8'h31,8'h12,8'h23,8'h05, 8'h2,8'h00,8'h00,8'h00,8'h00,8'h01,8'h01,8'h24,8'h06,8'hFF}
  };

  task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [79:0] state_now();
    return {6'b0, leap_o, hund_o, sec_o, min_o, hour_o, dom_o, mon_o, year_o, dow_o, roll_o};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 reset", {state_now()[79:8], 8'h0},
          {8'h00, 8'h00,8'h00,8'h00,8'h00,8'h01,8'h01,8'h00,8'h01, 8'h00});
    check("R1 reset save", {71'b0, save_en_o, sv_sec_o, sv_mon_o}, 80'h0);
    check("R1 reset roll", {72'b0, roll_o}, 80'h0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R11
    run = 1'b1;
    for (int i = 0; i < NV; i++) begin
      mode_12h = VEC[i].mode[0];
      wr(4'd8, VEC[i].leap);
      wr(4'd0, VEC[i].hund);
      wr(4'd1, VEC[i].sec);
      wr(4'd2, VEC[i].min);
      wr(4'd3, VEC[i].hour);
      wr(4'd4, VEC[i].dom);
      wr(4'd5, VEC[i].mon);
      wr(4'd6, VEC[i].year);
      wr(4'd7, VEC[i].dow);
      pulse_tick();
      check($sformatf("vector %0d (R2..R8, R11)", i), state_now(),
            {VEC[i].e_leap, VEC[i].e_hund, VEC[i].e_sec, VEC[i].e_min, VEC[i].e_hour,
             VEC[i].e_dom, VEC[i].e_mon, VEC[i].e_year, VEC[i].e_dow, VEC[i].e_roll});
      @(negedge clk);
      check($sformatf("vector %0d strobe width R11", i), {72'b0, roll_o}, 80'h0);
    end

    // R9 stopped chain ignores ticks
    mode_12h = 1'b0;
    wr(4'd0, 8'h99);
    wr(4'd1, 8'h59);
    run = 1'b0;
    @(negedge clk); tick = 1'b1;
    repeat (5) @(negedge clk);
    tick = 1'b0;
    check("R9 stopped", {64'b0, hund_o, sec_o}, {64'b0, 8'h99, 8'h59});
    check("R9 no strobe", {72'b0, roll_o}, 80'h0);

    // R10 write wins over an increment in the same cycle
    run = 1'b1;
    wr(4'd0, 8'h05);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_sel = 4'd0; wr_data = 8'h42;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    check("R10 write priority", {72'b0, hund_o}, {72'b0, 8'h42});

    // R10 masks of stored bits
    run = 1'b0;
    wr(4'd1, 8'hFF);
    wr(4'd2, 8'hFF);
    wr(4'd3, 8'hFF);
    wr(4'd4, 8'hFF);
    wr(4'd5, 8'hFF);
    wr(4'd7, 8'hFF);
    wr(4'd8, 8'hFF);
    check("R10 masks 24h", {24'b0, sec_o, min_o, hour_o, dom_o, mon_o, dow_o, 6'b0, leap_o},
          {24'b0, 8'h7F, 8'h7F, 8'h3F, 8'h3F, 8'h1F, 8'h07, 8'h03});
    mode_12h = 1'b1;
    wr(4'd3, 8'hFF);
    check("R10 mask 12h", {72'b0, hour_o}, {72'b0, 8'h9F});
    mode_12h = 1'b0;

    // R12 shadow follows, then holds
    wr(4'd1, 8'h12);
    wr(4'd2, 8'h34);
    wr(4'd3, 8'h05);
    wr(4'd4, 8'h06);
    wr(4'd5, 8'h07);
    @(negedge clk); ts_wr = 1'b1; ts_data = 1'b1;
    @(negedge clk); ts_wr = 1'b0;
    @(negedge clk);
    check("R12 tracking", {40'b0, sv_sec_o, sv_min_o, sv_hour_o, sv_dom_o, sv_mon_o},
          {40'b0, 8'h12, 8'h34, 8'h05, 8'h06, 8'h07});
    wr(4'd1, 8'h45);
    @(negedge clk);
    check("R12 tracks write", {72'b0, sv_sec_o}, {72'b0, 8'h45});
    @(negedge clk); ts_wr = 1'b1; ts_data = 1'b0;
    @(negedge clk); ts_wr = 1'b0;
    wr(4'd1, 8'h50);
    wr(4'd2, 8'h51);
    @(negedge clk);
    check("R12 frozen", {56'b0, save_en_o, 7'b0, sv_sec_o, sv_min_o},
          {56'b0, 1'b0, 7'b0, 8'h45, 8'h34});

    // R13 standby freezes a running clock
    begin
      logic [39:0] rec;
      @(negedge clk); ts_wr = 1'b1; ts_data = 1'b1;
      @(negedge clk); ts_wr = 1'b0;
      wr(4'd0, 8'h90);
      run = 1'b1; tick = 1'b1;
      repeat (17) @(negedge clk);
      rec = {sec_o, min_o, hour_o, dom_o, mon_o};
      standby = 1'b1; ts_wr = 1'b1; ts_data = 1'b1;
      @(negedge clk);
      standby = 1'b0; ts_wr = 1'b0;
      repeat (150) @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
      check("R13 flag cleared", {79'b0, save_en_o}, 80'h0);
      check("R13 frozen time", {40'b0, sv_sec_o, sv_min_o, sv_hour_o, sv_dom_o, sv_mon_o},
            {40'b0, rec});
      check("R13 live moved on", {79'b0, (sec_o != rec[39:32])}, 80'h1);
    end

    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end
endmodule